// File: doc/BRIEF.md
# Relocatable Peripheral Register Decoder

This block decodes the I/O address space of a peripheral controller. Two configuration registers are pinned at fixed addresses, 07F0h and 07F1h. Every other internal register of the controller sits in a 64-byte window whose base software can move in 40h steps. The base is written into the upper nibble of the register at 07F1h. That nibble stands for address bits A9..A6.

The register at 07F1h also holds a shutdown control bit. The register at 07F0h returns the system setup straps presented on an input port. A bus access that lands in the window is turned into a one-hot slot strobe and a write qualifier. Read data for the slot comes back from the register file outside this block. An access that hits nothing returns zero, and the hit flag stays low.

Top module: `reloc_io_decoder`

## Requirements
- R1: After reset the stored offset is 4'b0100 (window base 100h), the shutdown bit is 0, and `shdn_en` is 1.
- R2: A read of 07F1h returns the offset in bits 7..4 and the shutdown bit in bit 1. Bits 3, 2 and 0 read as 0.
- R3: A write to 07F1h loads wdata[7:4] into the offset and wdata[1] into the shutdown bit. The new values are visible from the next clock cycle. No other access changes them.
- R4: `shdn_en` is 1 while the shutdown bit is 0 (shutdown enabled) and 0 while it is 1 (disabled).
- R5: A read of 07F0h returns `strap_in`. A write to 07F0h changes no stored state.
- R6: With a read or write strobe, an address whose bits 15..10 are zero and whose bits 9..6 equal the offset hits the window. `win_sel` then has exactly bit addr[5:0] set, and `hit` is 1. A read returns `win_rdata`, and a write raises `win_we`.
- R7: Accesses to 07F0h and 07F1h are always served by the fixed registers, whatever the offset. For these accesses `win_sel` and `win_we` stay 0.
- R8: A strobed access that matches neither fixed address nor the window gives `hit`=0, `rdata`=0, `win_sel`=0 and `win_we`=0. With no strobe, all four are 0.
- R9: Changing the offset moves the window by 40h per offset step. The previous base then misses.
- R10: An address with bits 9..6 equal to the offset but any of bits 15..10 set misses the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| strap_in | input | 8 | Setup strap levels read at 07F0h |
| win_rdata | input | 8 | Read data from the selected window slot |
| rdata | output | 8 | Read data |
| hit | output | 1 | Access decoded by this block |
| win_sel | output | 64 | One-hot window slot strobe |
| win_we | output | 1 | Write qualifier for the selected slot |
| shdn_en | output | 1 | Shutdown enabled (1) |

## Verification
The decoder is probed with addresses at both edges of the window, just before and just after it, and at each of the sixteen offset positions. Together these show whether the comparison uses exactly bits 9..6. Aliases that differ only in bits 15..10 separate a full decode from a partial one. Reads and writes to the two fixed addresses are mixed in before and after offset changes. This shows whether the fixed registers win over the window and whether only 07F1h stores state. Write data with every bit set checks the unused bits of the readback.

// File: rtl/reloc_dec_pkg.sv
package reloc_dec_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_FIX0 = 2'd1,
      ACC_FIX1 = 2'd2,
      ACC_WIN  = 2'd3
   } acc_kind_e;

   localparam int unsigned SD_BIT = 1;
endpackage

// File: rtl/reloc_cfg_reg.sv
module reloc_cfg_reg #(
   parameter int unsigned OFS_W   = 4,
   parameter logic [3:0]  RST_OFS = 4'b0100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [OFS_W-1:0] ofs_in,
   input  logic             sd_in,
   output logic [OFS_W-1:0] ofs_q,
   output logic             sd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= RST_OFS[OFS_W-1:0];
         sd_q  <= 1'b0;
      end else if (ld) begin
         ofs_q <= ofs_in;
         sd_q  <= sd_in;
      end
   end

   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (ofs_q == $past(ofs_in) && sd_q == $past(sd_in)));
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> ($stable(ofs_q) && $stable(sd_q)));
endmodule

// File: rtl/reloc_window_dec.sv
module reloc_window_dec #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned OFS_LSB     = 6,
   parameter int unsigned OFS_W       = 4,
   parameter bit          FULL_DECODE = 1'b1,
   localparam int unsigned SLOTS      = 1 << OFS_LSB
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              en,
   output logic              win_hit,
   output logic [SLOTS-1:0]  win_sel
);
   localparam int unsigned TOP_LSB = OFS_LSB + OFS_W;

   logic base_match;
   logic upper_zero;

   assign base_match = (addr[TOP_LSB-1:OFS_LSB] == ofs);

   generate
      if (FULL_DECODE) begin : g_full
         if (TOP_LSB < ADDR_W) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
         end else begin : g_none
            assign upper_zero = 1'b1;
         end
      end else begin : g_alias
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign win_hit = en && base_match && upper_zero;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign win_sel[s] = win_hit && (addr[OFS_LSB-1:0] == s[OFS_LSB-1:0]);
   end
endmodule

// File: rtl/reloc_io_decoder.sv
module reloc_io_decoder #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OFS_LSB     = 6,
   parameter int unsigned OFS_W       = 4,
   parameter logic [15:0] FIX0_ADDR   = 16'h07F0,
   parameter logic [15:0] FIX1_ADDR   = 16'h07F1,
   parameter logic [3:0]  RST_OFS     = 4'b0100,
   parameter bit          FULL_DECODE = 1'b1,
   localparam int unsigned SLOTS      = 1 << OFS_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] strap_in,
   input  logic [DATA_W-1:0] win_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              hit,
   output logic [SLOTS-1:0]  win_sel,
   output logic              win_we,
   output logic              shdn_en
);
   import reloc_dec_pkg::*;

   if (OFS_LSB + OFS_W > ADDR_W) begin : g_chk_addr
      $error("offset field does not fit the address width");
   end
   if (DATA_W < OFS_W + SD_BIT + 1) begin : g_chk_data
      $error("data width too narrow for the configuration fields");
   end
   if (ADDR_W > 16) begin : g_chk_fix
      $error("fixed addresses are 16-bit");
   end

   logic              acc;
   logic              is_fix0;
   logic              is_fix1;
   logic              win_hit;
   logic [OFS_W-1:0]  ofs_q;
   logic              sd_q;
   logic [DATA_W-1:0] cfg_rd;
   acc_kind_e         kind;

   assign acc     = rd_en || wr_en;
   assign is_fix0 = (addr == FIX0_ADDR[ADDR_W-1:0]);
   assign is_fix1 = (addr == FIX1_ADDR[ADDR_W-1:0]);

   reloc_cfg_reg #(.OFS_W(OFS_W), .RST_OFS(RST_OFS)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (wr_en && is_fix1),
      .ofs_in (wdata[DATA_W-1 -: OFS_W]),
      .sd_in  (wdata[SD_BIT]),
      .ofs_q  (ofs_q),
      .sd_q   (sd_q)
   );

   reloc_window_dec #(
      .ADDR_W(ADDR_W), .OFS_LSB(OFS_LSB), .OFS_W(OFS_W), .FULL_DECODE(FULL_DECODE)
   ) u_win (
      .addr    (addr),
      .ofs     (ofs_q),
      .en      (acc && !is_fix0 && !is_fix1),
      .win_hit (win_hit),
      .win_sel (win_sel)
   );

   always_comb begin
      if (!acc)         kind = ACC_NONE;
      else if (is_fix1) kind = ACC_FIX1;
      else if (is_fix0) kind = ACC_FIX0;
      else if (win_hit) kind = ACC_WIN;
      else              kind = ACC_NONE;
   end

   always_comb begin
      cfg_rd = '0;
      cfg_rd[DATA_W-1 -: OFS_W] = ofs_q;
      cfg_rd[SD_BIT] = sd_q;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (kind)
            ACC_FIX1: rdata = cfg_rd;
            ACC_FIX0: rdata = strap_in;
            ACC_WIN:  rdata = win_rdata;
            default:  rdata = '0;
         endcase
      end
   end

   assign hit     = (kind != ACC_NONE);
   assign win_we  = wr_en && (kind == ACC_WIN);
   assign shdn_en = !sd_q;

   a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_sel));
   a_r6_sel_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel != '0) |-> hit);
   a_r7_fixed_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (is_fix0 || is_fix1)) |-> (win_sel == '0 && !win_we && hit));
   a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rdata == '0 && win_sel == '0 && !win_we));
   a_r4_shdn: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && is_fix1) |-> (rdata[SD_BIT] == !shdn_en));
endmodule

// File: tb/reloc_io_decoder_tb.sv
module reloc_io_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  strap_in = 8'hA5;
   logic [7:0]  win_rdata = 8'h3C;
   logic [7:0]  rdata;
   logic        hit;
   logic [63:0] win_sel;
   logic        win_we;
   logic        shdn_en;

   int vectors = 0;
   int errors  = 0;
   int m_ofs   = 4;
   int m_sd    = 0;

   always #4 clk = ~clk;

   reloc_io_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .rd_en(rd_en), .wr_en(wr_en), .strap_in(strap_in), .win_rdata(win_rdata),
      .rdata(rdata), .hit(hit), .win_sel(win_sel), .win_we(win_we), .shdn_en(shdn_en)
   );

   task automatic cmp(input string req, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input string req, input bit rd, input bit wr,
                      input logic [15:0] a, input logic [7:0] d);
      bit          f0, f1, win, acc;
      logic [7:0]  e_rd;
      logic [63:0] e_sel;
      @(negedge clk);
      rd_en = rd; wr_en = wr; addr = a; wdata = d;
      #2;
      acc = rd | wr;
      f0  = (a == 16'h07F0);
      f1  = (a == 16'h07F1);
      win = !f0 && !f1 && (a[15:10] == 0) && (int'(a[9:6]) == m_ofs);
      e_rd = 8'h00;
      if (rd) begin
         if (f1)      e_rd = {m_ofs[3:0], 2'b00, m_sd[0], 1'b0};
         else if (f0) e_rd = strap_in;
         else if (win) e_rd = win_rdata;
      end
      e_sel = (acc && win) ? (64'd1 << a[5:0]) : 64'd0;
      cmp(req, "rdata", rdata, e_rd);
      cmp(req, "hit", hit, acc && (f0 || f1 || win));
      cmp(req, "win_sel", win_sel, e_sel);
      cmp(req, "win_we", win_we, wr && win);
      cmp(req, "shdn_en", shdn_en, m_sd == 0);
      @(posedge clk);
      if (wr && f1) begin
         m_ofs = int'(d[7:4]);
         m_sd  = int'(d[1]);
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state seen through R2 readback
      cyc("R1", 1, 0, 16'h07F1, 8'h00);
      cmp("R1", "reset readback", rdata, 8'h40);
      cyc("R8", 0, 0, 16'h0100, 8'h00);
      // R5 strap port and write immunity
      cyc("R5", 1, 0, 16'h07F0, 8'h00);
      cyc("R5", 0, 1, 16'h07F0, 8'hFF);
      cyc("R5", 1, 0, 16'h07F1, 8'h00);
      strap_in = 8'h5A;
      cyc("R5", 1, 0, 16'h07F0, 8'h00);
      // R6 window at default base 100h
      cyc("R6", 1, 0, 16'h0100, 8'h00);
      cyc("R6", 1, 0, 16'h013F, 8'h00);
      cyc("R6", 0, 1, 16'h0105, 8'h11);
      win_rdata = 8'hC3;
      cyc("R6", 1, 0, 16'h0120, 8'h00);
      // R8 just outside the window
      cyc("R8", 1, 0, 16'h00FF, 8'h00);
      cyc("R8", 1, 0, 16'h0140, 8'h00);
      cyc("R8", 0, 1, 16'h0140, 8'h22);
      // R10 aliases in upper bits
      cyc("R10", 1, 0, 16'h0500, 8'h00);
      cyc("R10", 0, 1, 16'h8100, 8'h00);
      // R3 R4 R2 write all ones
      cyc("R3", 0, 1, 16'h07F1, 8'hFF);
      cyc("R2", 1, 0, 16'h07F1, 8'h00);
      cmp("R2", "unused bits zero", rdata & 8'h0D, 8'h00);
      cmp("R4", "shdn disabled", shdn_en, 1'b0);
      // R9 window moved to 3C0h
      cyc("R9", 1, 0, 16'h03C0, 8'h00);
      cyc("R9", 1, 0, 16'h0100, 8'h00);
      // R7 fixed registers still reachable, incl. 7C0h alias area
      cyc("R7", 1, 0, 16'h07F1, 8'h00);
      cyc("R7", 0, 1, 16'h07F0, 8'h00);
      cyc("R10", 1, 0, 16'h07C1, 8'h00);
      // R9 sweep every offset
      for (int o = 0; o < 16; o++) begin
         cyc("R3", 0, 1, 16'h07F1, 8'((o << 4) | ((o & 1) << 1)));
         cyc("R9", 1, 0, 16'((o << 6) | (o * 3 % 64)), 8'h00);
         cyc("R9", 0, 1, 16'((o << 6) + 63), 8'h00);
         cyc("R9", 1, 0, 16'(((o + 1) % 16) << 6), 8'h00);
         cyc("R4", 1, 0, 16'h07F1, 8'h00);
      end
      // R1 reset again restores defaults
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      rst_n = 1'b0;
      m_ofs = 4; m_sd = 0;
      #10 rst_n = 1'b1;
      cyc("R1", 1, 0, 16'h07F1, 8'h00);
      cyc("R1", 1, 0, 16'h0100, 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule